// File: doc/BRIEF.md
# CAN Status and Fault-Level Register Block

This block sits beside a CAN protocol engine. It takes the engine's event strobes and its fault-confinement counter values and turns them into three things a CPU can read: a status word, an error-count word and an interrupt identifier. The status word holds a 3-bit last-event code, two sticky success flags (frame sent, frame received) and three fault-level flags: warning, passive and bus-off. The fault-level flags are worked out from the counter values, which arrive as inputs. This block does not count errors itself.

The CPU can write code 7 into the code field. That value stays until the engine reports a new event, so software can tell whether any bus activity happened since its write. A new event, or any change of a fault-level flag, can raise a pending status interrupt, subject to two enable bits in the control word. The interrupt identifier word then reads 0x8000. A read of the status word clears the pending interrupt.

The pending interrupt is a two-state machine. Its states are `IRQ_IDLE` (nothing pending) and `IRQ_PEND` (status interrupt pending). It has three transitions:
- **raise**: `IRQ_IDLE` to `IRQ_PEND`, on an enabled cause.
- **ack**: `IRQ_PEND` to `IRQ_IDLE`, on a status read in a cycle with no cause.
- **hold**: stay in `IRQ_PEND` when a cause and a status read arrive in the same cycle.

Top module: `can_err_status`

## Requirements
- R1: After reset every register reads 0 and `irq_o` is low.
- R2: The status word (offset 1) has this layout: code in bits 2:0, sent flag in bit 3, received flag in bit 4, passive in bit 5, warning in bit 6, bus-off in bit 7, and zero above bit 7. An `evt_valid` strobe loads `evt_code` into the code field at the next clock edge. A `tx_ok` pulse sets bit 3 and a `rx_ok` pulse sets bit 4, and either pulse loads code 0 unless `evt_valid` is high in the same cycle.
- R3: Code values are 0 none, 1 stuff, 2 form, 3 acknowledge, 4 recessive-bit, 5 dominant-bit, 6 CRC and 7 not-updated. A CPU write to the status word stores bits 2:0 in the code field. A stored 7 stays until an engine event. An engine event in the same cycle as a CPU write wins.
- R4: Writing 0 to bit 3 or bit 4 of the status word clears that flag, and writing 1 leaves it unchanged. A set pulse in the same cycle as a clearing write wins.
- R5: The flags are updated one clock after the counts are sampled. Warning is set while either count is 96 or more. Passive is set while either count is 128 or more. Bus-off is set while the transmit count is 256 or more.
- R6: The error-count word (offset 2) is laid out as follows:
  - bits 7:0: transmit count, saturated at 255.
  - bits 14:8: receive count, saturated at 127.
  - bit 15: set while the receive count is 128 or more.
- R7: A status interrupt becomes pending on either of two causes:
  - an engine event (`evt_valid`, `tx_ok` or `rx_ok`) while control bit 1 is set;
  - a change in any fault-level flag while control bit 2 is set.
  With the relevant bit clear, the cause has no effect.
- R8: The interrupt identifier word (offset 3) reads 0x8000 while an interrupt is pending and 0 otherwise. `irq_o` is high when an interrupt is pending and control bit 0 is set.
- R9: A read of the status word (`bus_rd` at offset 1) clears the pending interrupt. A cause in the same cycle keeps it pending.
- R10: The control word (offset 0) has bits 2:0 writable and all other bits read 0. Writes to offsets 2 and 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register word select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (a status read acknowledges the interrupt) |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| evt_valid | input | 1 | Engine reports a bus event with a code |
| evt_code | input | 3 | Event code |
| tx_ok | input | 1 | Frame sent successfully |
| rx_ok | input | 1 | Frame received successfully |
| tec_in | input | TEC_W | Transmit error count from the engine |
| rec_in | input | REC_W | Receive error count from the engine |
| irq_o | output | 1 | Status interrupt line |

## Verification
Some rules hold at every clock edge, and the assertions check those continuously:
- a stored code 7 is kept while there is no event and no write;
- an engine event always lands in the code field;
- a set sent flag survives any cycle without a clearing write;
- bus-off never appears without passive and warning;
- the pending bit only rises after a cause, always rises after a cause, and drops after an acknowledge that had no cause.

Other behaviour can only be shown by the bench's reference model and scenarios. This covers the exact threshold edges (95 against 96, 127 against 128), counter saturation in the count word, the enable gating of each cause, and the same-cycle precedence between CPU writes and engine strobes.

// File: rtl/can_err_status_pkg.sv
package can_err_status_pkg;

    typedef enum logic [0:0] {
        IRQ_IDLE = 1'b0,
        IRQ_PEND = 1'b1
    } irq_state_t;

    typedef struct packed {
        logic boff;
        logic ewarn;
        logic epass;
    } fault_lvl_t;

    localparam int unsigned OFS_CTRL = 0;
    localparam int unsigned OFS_STAT = 1;
    localparam int unsigned OFS_ECNT = 2;
    localparam int unsigned OFS_IRQ  = 3;

    localparam logic [2:0] CODE_NONE  = 3'd0;
    localparam logic [2:0] CODE_STUFF = 3'd1;
    localparam logic [2:0] CODE_FORM  = 3'd2;
    localparam logic [2:0] CODE_ACK   = 3'd3;
    localparam logic [2:0] CODE_BIT1  = 3'd4;
    localparam logic [2:0] CODE_BIT0  = 3'd5;
    localparam logic [2:0] CODE_CRC   = 3'd6;
    localparam logic [2:0] CODE_HOLD  = 3'd7;

    localparam int unsigned CTRL_BITS   = 3;
    localparam int unsigned CTRL_MASTER = 0;
    localparam int unsigned CTRL_EVT_IE = 1;
    localparam int unsigned CTRL_LVL_IE = 2;

    localparam int unsigned STAT_TXOK = 3;
    localparam int unsigned STAT_RXOK = 4;

    localparam logic [15:0] IRQ_ID_STATUS = 16'h8000;

endpackage

// File: rtl/can_err_level.sv
module can_err_level
    import can_err_status_pkg::*;
#(
    parameter int unsigned TEC_W    = 9,
    parameter int unsigned REC_W    = 8,
    parameter int unsigned TEC_FLD  = 8,
    parameter int unsigned REC_FLD  = 7,
    parameter int unsigned WARN_LIM = 96,
    parameter int unsigned PASS_LIM = 128,
    parameter int unsigned BOFF_LIM = 256
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [TEC_W-1:0]   tec_i,
    input  logic [REC_W-1:0]   rec_i,
    output fault_lvl_t         lvl_q,
    output logic               lvl_changed,
    output logic [TEC_FLD-1:0] tec_q,
    output logic [REC_FLD-1:0] rec_q,
    output logic               rx_pass_q
);

    localparam logic [TEC_W-1:0] T_WARN = TEC_W'(WARN_LIM);
    localparam logic [TEC_W-1:0] T_PASS = TEC_W'(PASS_LIM);
    localparam logic [TEC_W-1:0] T_BOFF = TEC_W'(BOFF_LIM);
    localparam logic [REC_W-1:0] R_WARN = REC_W'(WARN_LIM);
    localparam logic [REC_W-1:0] R_PASS = REC_W'(PASS_LIM);

    fault_lvl_t         lvl_d;
    logic [TEC_FLD-1:0] tec_d;
    logic [REC_FLD-1:0] rec_d;
    logic               rx_pass_d;

    always_comb begin
        lvl_d.ewarn = (tec_i >= T_WARN) || (rec_i >= R_WARN);
        lvl_d.epass = (tec_i >= T_PASS) || (rec_i >= R_PASS);
        lvl_d.boff  = (tec_i >= T_BOFF);
        rx_pass_d   = (rec_i >= R_PASS);
        lvl_changed = (lvl_d != lvl_q);
    end

    generate
        if (TEC_W > TEC_FLD) begin : g_tec_sat
            localparam logic [TEC_W-1:0] T_TOP = TEC_W'((1 << TEC_FLD) - 1);
            assign tec_d = (tec_i > T_TOP) ? '1 : tec_i[TEC_FLD-1:0];
        end else begin : g_tec_pass
            assign tec_d = TEC_FLD'(tec_i);
        end
        if (REC_W > REC_FLD) begin : g_rec_sat
            localparam logic [REC_W-1:0] R_TOP = REC_W'((1 << REC_FLD) - 1);
            assign rec_d = (rec_i > R_TOP) ? '1 : rec_i[REC_FLD-1:0];
        end else begin : g_rec_pass
            assign rec_d = REC_FLD'(rec_i);
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q     <= '0;
            tec_q     <= '0;
            rec_q     <= '0;
            rx_pass_q <= 1'b0;
        end else begin
            lvl_q     <= lvl_d;
            tec_q     <= tec_d;
            rec_q     <= rec_d;
            rx_pass_q <= rx_pass_d;
        end
    end

    AST_BOFF_IMPLIES_PASSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_q.boff |-> (lvl_q.epass && lvl_q.ewarn)); // R5

endmodule

// File: rtl/can_err_irq_fsm.sv
module can_err_irq_fsm
    import can_err_status_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cause_i,
    input  logic ack_i,
    output logic pend_o
);

    irq_state_t state_q;
    irq_state_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE: if (cause_i)            state_d = IRQ_PEND;
            IRQ_PEND: if (ack_i && !cause_i)  state_d = IRQ_IDLE;
            default:                          state_d = IRQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        pend_o = (state_q == IRQ_PEND);
    end

    AST_PEND_NEEDS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_o) |-> $past(cause_i)); // R7
    AST_CAUSE_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        cause_i |=> pend_o); // R7
    AST_ACK_CLEARS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !cause_i) |=> !pend_o); // R9

endmodule

// File: rtl/can_err_status.sv
module can_err_status
    import can_err_status_pkg::*;
#(
    parameter int unsigned ADDR_W   = 2,
    parameter int unsigned DATA_W   = 16,
    parameter int unsigned TEC_W    = 9,
    parameter int unsigned REC_W    = 8,
    parameter int unsigned WARN_LIM = 96,
    parameter int unsigned PASS_LIM = 128,
    parameter int unsigned BOFF_LIM = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              evt_valid,
    input  logic [2:0]        evt_code,
    input  logic              tx_ok,
    input  logic              rx_ok,
    input  logic [TEC_W-1:0]  tec_in,
    input  logic [REC_W-1:0]  rec_in,
    output logic              irq_o
);

    localparam int unsigned TEC_FLD = 8;
    localparam int unsigned REC_FLD = 7;
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
    localparam logic [ADDR_W-1:0] A_ECNT = ADDR_W'(OFS_ECNT);
    localparam logic [ADDR_W-1:0] A_IRQ  = ADDR_W'(OFS_IRQ);

    logic [CTRL_BITS-1:0] ctrl_q;
    logic [2:0]           code_q;
    logic                 txok_q;
    logic                 rxok_q;

    fault_lvl_t           lvl_q;
    logic                 lvl_changed;
    logic [TEC_FLD-1:0]   tec_q;
    logic [REC_FLD-1:0]   rec_q;
    logic                 rx_pass_q;
    logic                 pend;

    logic ctrl_wr;
    logic stat_wr;
    logic stat_rd;
    logic evt_any;
    logic irq_cause;

    assign ctrl_wr   = bus_wr && (bus_addr == A_CTRL);
    assign stat_wr   = bus_wr && (bus_addr == A_STAT);
    assign stat_rd   = bus_rd && (bus_addr == A_STAT);
    assign evt_any   = evt_valid || tx_ok || rx_ok;
    assign irq_cause = (evt_any && ctrl_q[CTRL_EVT_IE]) ||
                       (lvl_changed && ctrl_q[CTRL_LVL_IE]);

    can_err_level #(
        .TEC_W    (TEC_W),
        .REC_W    (REC_W),
        .TEC_FLD  (TEC_FLD),
        .REC_FLD  (REC_FLD),
        .WARN_LIM (WARN_LIM),
        .PASS_LIM (PASS_LIM),
        .BOFF_LIM (BOFF_LIM)
    ) u_level (
        .clk         (clk),
        .rst_n       (rst_n),
        .tec_i       (tec_in),
        .rec_i       (rec_in),
        .lvl_q       (lvl_q),
        .lvl_changed (lvl_changed),
        .tec_q       (tec_q),
        .rec_q       (rec_q),
        .rx_pass_q   (rx_pass_q)
    );

    can_err_irq_fsm u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .cause_i (irq_cause),
        .ack_i   (stat_rd),
        .pend_o  (pend)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            code_q <= CODE_NONE;
            txok_q <= 1'b0;
            rxok_q <= 1'b0;
        end else begin
            if (ctrl_wr)
                ctrl_q <= bus_wdata[CTRL_BITS-1:0];

            if (evt_valid)
                code_q <= evt_code;
            else if (tx_ok || rx_ok)
                code_q <= CODE_NONE;
            else if (stat_wr)
                code_q <= bus_wdata[2:0];

            if (tx_ok)
                txok_q <= 1'b1;
            else if (stat_wr && !bus_wdata[STAT_TXOK])
                txok_q <= 1'b0;

            if (rx_ok)
                rxok_q <= 1'b1;
            else if (stat_wr && !bus_wdata[STAT_RXOK])
                rxok_q <= 1'b0;
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_CTRL:  bus_rdata = DATA_W'(ctrl_q);
            A_STAT:  bus_rdata = DATA_W'({lvl_q.boff, lvl_q.ewarn, lvl_q.epass,
                                          rxok_q, txok_q, code_q});
            A_ECNT:  bus_rdata = DATA_W'({rx_pass_q, rec_q, tec_q});
            A_IRQ:   bus_rdata = pend ? DATA_W'(IRQ_ID_STATUS) : '0;
            default: bus_rdata = '0;
        endcase
    end

    assign irq_o = pend && ctrl_q[CTRL_MASTER];

    AST_CODE_SENTINEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (code_q == CODE_HOLD && !evt_any && !stat_wr) |=> (code_q == CODE_HOLD)); // R3
    AST_ENGINE_CODE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |=> (code_q == $past(evt_code))); // R3
    AST_TXOK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (txok_q && !(stat_wr && !bus_wdata[STAT_TXOK])) |=> txok_q); // R4

endmodule

// File: tb/can_err_status_tb.sv
module can_err_status_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        evt_valid = 1'b0;
    logic [2:0]  evt_code = '0;
    logic        tx_ok = 1'b0;
    logic        rx_ok = 1'b0;
    logic [8:0]  tec_in = '0;
    logic [7:0]  rec_in = '0;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    can_err_status u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .evt_valid (evt_valid),
        .evt_code  (evt_code),
        .tx_ok     (tx_ok),
        .rx_ok     (rx_ok),
        .tec_in    (tec_in),
        .rec_in    (rec_in),
        .irq_o     (irq_o)
    );

    // behavioural reference model
    int m_ctrl, m_code, m_tx, m_rx, m_ew, m_ep, m_bo, m_tecc, m_recc, m_rp, m_pend;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ctrl = 0; m_code = 0; m_tx = 0; m_rx = 0; m_ew = 0; m_ep = 0;
            m_bo = 0; m_tecc = 0; m_recc = 0; m_rp = 0; m_pend = 0;
        end else begin
            int t, r, ew, ep, bo, chg, ev, cause, wst;
            t  = int'(tec_in);
            r  = int'(rec_in);
            ew = (t >= 96 || r >= 96) ? 1 : 0;
            ep = (t >= 128 || r >= 128) ? 1 : 0;
            bo = (t >= 256) ? 1 : 0;
            chg = (ew != m_ew || ep != m_ep || bo != m_bo) ? 1 : 0;
            ev = (evt_valid || tx_ok || rx_ok) ? 1 : 0;
            cause = ((ev == 1 && ((m_ctrl >> 1) & 1) == 1) ||
                     (chg == 1 && ((m_ctrl >> 2) & 1) == 1)) ? 1 : 0;
            wst = (bus_wr && bus_addr == 2'd1) ? 1 : 0;
            if (cause == 1) m_pend = 1;
            else if (bus_rd && bus_addr == 2'd1) m_pend = 0;
            if (evt_valid) m_code = int'(evt_code);
            else if (tx_ok || rx_ok) m_code = 0;
            else if (wst == 1) m_code = int'(bus_wdata[2:0]);
            if (tx_ok) m_tx = 1;
            else if (wst == 1 && !bus_wdata[3]) m_tx = 0;
            if (rx_ok) m_rx = 1;
            else if (wst == 1 && !bus_wdata[4]) m_rx = 0;
            if (bus_wr && bus_addr == 2'd0) m_ctrl = int'(bus_wdata[2:0]);
            m_ew = ew; m_ep = ep; m_bo = bo;
            m_tecc = (t > 255) ? 255 : t;
            m_recc = (r > 127) ? 127 : r;
            m_rp = (r > 127) ? 1 : 0;
        end
    end

    function automatic int exp_rd(input int a);
        case (a)
            0: return m_ctrl;
            1: return (m_bo << 7) | (m_ew << 6) | (m_ep << 5) | (m_rx << 4) | (m_tx << 3) | m_code;
            2: return (m_rp << 15) | (m_recc << 8) | m_tecc;
            default: return (m_pend == 1) ? 32'h8000 : 0;
        endcase
    endfunction

    function automatic string tag_of(input int a);
        case (a)
            0: return "R10";
            1: return "R2";
            2: return "R6";
            default: return "R8";
        endcase
    endfunction

    // compare against the model on every clock
    always @(negedge clk) begin
        if (rst_n && !done) begin
            int e;
            e = exp_rd(int'(bus_addr));
            checks++;
            if (int'(bus_rdata) != e) begin
                errors++;
                $display("FAIL %s model rdata addr %0d actual %h expected %h",
                         tag_of(int'(bus_addr)), bus_addr, bus_rdata, e);
            end
            checks++;
            if (irq_o != (m_pend == 1 && (m_ctrl & 1) == 1)) begin
                errors++;
                $display("FAIL R8 model irq_o actual %0b expected %0b",
                         irq_o, (m_pend == 1 && (m_ctrl & 1) == 1));
            end
        end
    end

    task automatic step();
        @(posedge clk); #2;
    endtask

    task automatic chk_rd(input int a, input int mask, input int exp, input string tag);
        step();
        bus_addr = 2'(a);
        @(negedge clk); #1;
        checks++;
        if ((int'(bus_rdata) & mask) != exp) begin
            errors++;
            $display("FAIL %s addr %0d actual %h expected %h", tag, a,
                     int'(bus_rdata) & mask, exp);
        end
    endtask

    task automatic chk_irq(input bit exp, input string tag);
        @(negedge clk); #1;
        checks++;
        if (irq_o != exp) begin
            errors++;
            $display("FAIL %s irq_o actual %0b expected %0b", tag, irq_o, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        step();
        bus_addr = 2'(a); bus_wdata = 16'(d); bus_wr = 1'b1;
        step();
        bus_wr = 1'b0;
    endtask

    task automatic evt(input int c);
        step();
        evt_valid = 1'b1; evt_code = 3'(c);
        step();
        evt_valid = 1'b0;
    endtask

    task automatic set_cnt(input int t, input int r);
        step();
        tec_in = 9'(t); rec_in = 8'(r);
        step();
    endtask

    task automatic rd_clear();
        step();
        bus_addr = 2'd1; bus_rd = 1'b1;
        step();
        bus_rd = 1'b0;
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        // R1 reset state
        for (int a = 0; a < 4; a++) chk_rd(a, 16'hFFFF, 0, "R1");
        chk_irq(1'b0, "R1");

        // R10 control word and ignored writes
        wr(0, 16'hFFFF);
        chk_rd(0, 16'hFFFF, 7, "R10");
        wr(2, 16'h1234);
        chk_rd(2, 16'hFFFF, 0, "R10");
        wr(3, 16'h5555);
        chk_rd(3, 16'hFFFF, 0, "R10");

        // R2 event code, R8 identifier, R9 clear on status read
        evt(3);
        chk_rd(1, 16'h0007, 3, "R2");
        chk_rd(3, 16'hFFFF, 16'h8000, "R8");
        chk_irq(1'b1, "R8");
        rd_clear();
        chk_rd(3, 16'hFFFF, 0, "R9");

        // R3 sentinel held
        wr(1, 7);
        repeat (3) step();
        chk_rd(1, 16'h0007, 7, "R3");
        step(); tx_ok = 1'b1; step(); tx_ok = 1'b0;
        chk_rd(1, 16'h001F, 16'h0008, "R2");
        step(); rx_ok = 1'b1; step(); rx_ok = 1'b0;
        chk_rd(1, 16'h001F, 16'h0018, "R2");

        // R4 clear by writing 0, keep with 1, set wins
        wr(1, 16'h0008);
        chk_rd(1, 16'h0018, 16'h0008, "R4");
        step();
        bus_addr = 2'd1; bus_wdata = 16'h0007; bus_wr = 1'b1; tx_ok = 1'b1;
        step();
        bus_wr = 1'b0; tx_ok = 1'b0;
        chk_rd(1, 16'h001F, 16'h0008, "R4");
        wr(1, 0);
        chk_rd(1, 16'h0018, 0, "R4");
        step();
        bus_addr = 2'd1; bus_wdata = 16'h0007; bus_wr = 1'b1;
        evt_valid = 1'b1; evt_code = 3'd5;
        step();
        bus_wr = 1'b0; evt_valid = 1'b0;
        chk_rd(1, 16'h0007, 5, "R3");

        // R5 thresholds, R6 count word
        rd_clear();
        set_cnt(96, 0);
        chk_rd(1, 16'h00E0, 16'h0040, "R5");
        set_cnt(95, 0);
        chk_rd(1, 16'h00E0, 0, "R5");
        set_cnt(128, 0);
        chk_rd(1, 16'h00E0, 16'h0060, "R5");
        set_cnt(127, 96);
        chk_rd(1, 16'h00E0, 16'h0040, "R5");
        set_cnt(256, 0);
        chk_rd(1, 16'h00E0, 16'h00E0, "R5");
        chk_rd(2, 16'hFFFF, 16'h00FF, "R6");
        set_cnt(10, 200);
        chk_rd(1, 16'h00E0, 16'h0060, "R5");
        chk_rd(2, 16'hFFFF, 16'hFF0A, "R6");
        set_cnt(5, 100);
        chk_rd(2, 16'hFFFF, 16'h6405, "R6");

        // R7 gating of causes
        wr(0, 0);
        rd_clear();
        evt(1);
        chk_rd(3, 16'hFFFF, 0, "R7");
        set_cnt(0, 0);
        chk_rd(3, 16'hFFFF, 0, "R7");
        wr(0, 2);
        set_cnt(96, 0);
        chk_rd(3, 16'hFFFF, 0, "R7");
        evt(2);
        chk_rd(3, 16'hFFFF, 16'h8000, "R7");
        chk_irq(1'b0, "R8");
        wr(0, 3);
        chk_irq(1'b1, "R8");
        wr(0, 4);
        rd_clear();
        chk_rd(3, 16'hFFFF, 0, "R9");
        set_cnt(0, 0);
        chk_rd(3, 16'hFFFF, 16'h8000, "R7");

        // R9 cause and read in the same cycle
        wr(0, 2);
        rd_clear();
        step();
        bus_addr = 2'd1; bus_rd = 1'b1; evt_valid = 1'b1; evt_code = 3'd6;
        step();
        bus_rd = 1'b0; evt_valid = 1'b0;
        chk_rd(3, 16'hFFFF, 16'h8000, "R9");
        rd_clear();
        chk_rd(3, 16'hFFFF, 0, "R9");

        repeat (2) step();
        done = 1'b1;
        summary();
        $finish;
    end

endmodule